// File: doc/BRIEF.md
# 4x4 Forward Integer Transform Engine

This block takes one 4x4 tile of signed 16-bit residual samples and returns sixteen signed 16-bit transform coefficients. The arithmetic is fixed-point and bit-exact. A host presents all sixteen samples in parallel and pulses `start`. The engine copies the tile into an internal working matrix. It then runs a horizontal pass, one row per clock, and after that a vertical pass, one column per clock. Both passes overwrite the matrix in place. The finished coefficients appear on a packed output bus in raster order, and a one-cycle `done` pulse marks them.

The horizontal pass uses saturating 16-bit butterflies. It scales the even terms by eight and rounds the odd terms with the weights 2217 and 5352 and a shift of 12. The vertical pass does not saturate. It rounds the even terms with +7 and a shift of 4, and the odd terms with a shift of 16. One odd output gets an extra +1 whenever its difference term is nonzero. All intermediate products are held at 32 bits, and each stored value is truncated to its low 16 bits.

A four-state sequencer controls the work:
- `ST_IDLE` waits for a start.
- `ST_ROW` walks the four rows.
- `ST_COL` walks the four columns.
- `ST_FIN` drives the result pulse.

The transitions are:
- ACCEPT: `ST_IDLE` to `ST_ROW` when `start` is high.
- ROWS_DONE: `ST_ROW` to `ST_COL` after the last row.
- COLS_DONE: `ST_COL` to `ST_FIN` after the last column.
- RELEASE: `ST_FIN` to `ST_IDLE` unconditionally.

Top module: `fdct4x4_core`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every coefficient on `coef_out` is 0.
- R2: In the horizontal pass, each row x0..x3 forms a=x0+x3, b=x1+x2, c=x1-x2 and d=x0-x3, each clamped to the range -32768..32767.
- R3: Horizontal outputs 0 and 2 of each row are (a+b)*8 and (a-b)*8, truncated to 16 bits.
- R4: Horizontal output 1 of each row is (c*2217 + d*5352 + 14500) >>> 12. Output 3 is (d*2217 - c*5352 + 7500) >>> 12. Both are truncated to 16 bits.
- R5: In the vertical pass, each column r0..r3 of the horizontal results forms a=r0+r3, b=r1+r2, c=r1-r2 and d=r0-r3 without clamping. Outputs 0 and 2 are (a+b+7) >>> 4 and (a-b+7) >>> 4.
- R6: Vertical output 1 is ((c*2217 + d*5352 + 12000) >>> 16) plus 1 when d is nonzero, and plus nothing when d is zero.
- R7: Vertical output 3 is (d*2217 - c*5352 + 51000) >>> 16.
- R8: Sample and coefficient (row i, column j) both occupy bits [16*(4*i+j) +: 16] of `blk_in` and `coef_out`. Coefficient row i is vertical output i.
- R9: `done` is high for exactly one cycle. That cycle follows the eighth rising edge after the edge that samples `start`, and `busy` stays high from the accepting edge through that cycle.
- R10: A `start` that arrives while `busy` is high is ignored. The running result and its timing are unchanged, and no new computation follows.
- R11: `coef_out` holds its value from `done` until the next accepted `start`, even if `blk_in` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin transforming `blk_in` when idle |
| blk_in | input | 256 | Sixteen signed 16-bit samples, raster packed |
| busy | output | 1 | High while a tile is in progress |
| done | output | 1 | One-cycle pulse when `coef_out` is valid |
| coef_out | output | 256 | Sixteen signed 16-bit coefficients, raster packed |

## Verification
On every cycle, the assertions check the sequencer's behaviour. They confirm that at most one matrix-update strobe is active at a time and that `done` is a single-cycle pulse. They confirm that `done` only follows the final column step and that a tile in progress cannot be aborted. They also confirm that `coef_out` stays stable whenever the engine is idle and no start arrives.

The numerical behaviour can only be shown by the bench's scenarios, which compare results against an independent integer model. These scenarios cover:
- the clamping of the horizontal butterfly at full-scale inputs;
- the data-dependent +1 on vertical output 1, for both a zero and a nonzero difference term;
- raster placement;
- the exact latency;
- the rejection of starts that arrive mid-tile or on the `done` cycle.

// File: rtl/fdct_pkg.sv
package fdct_pkg;

    localparam int SMP_W = 16;
    localparam int ACC_W = 32;
    localparam int DIM   = 4;
    localparam int NUM   = DIM * DIM;
    localparam int SEL_W = $clog2(DIM);

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_FIN
    } phase_e;

    // transform weights and rounding offsets
    localparam acc_t W_SMALL   = 32'sd2217;
    localparam acc_t W_LARGE   = 32'sd5352;
    localparam acc_t H_RND_ODD1 = 32'sd14500;
    localparam acc_t H_RND_ODD3 = 32'sd7500;
    localparam int   H_GAIN_SH  = 3;
    localparam int   H_ODD_SH   = 12;
    localparam acc_t V_RND_EVEN = 32'sd7;
    localparam acc_t V_RND_ODD1 = 32'sd12000;
    localparam acc_t V_RND_ODD3 = 32'sd51000;
    localparam int   V_EVEN_SH  = 4;
    localparam int   V_ODD_SH   = 16;

    localparam acc_t SMP_MAX = acc_t'((64'sd1 <<< (SMP_W - 1)) - 1);
    localparam acc_t SMP_MIN = -acc_t'(64'sd1 <<< (SMP_W - 1));

    // clamp a wide value into the sample range
    function automatic smp_t clip_s(input acc_t v);
        if (v > SMP_MAX)      clip_s = SMP_MAX[SMP_W-1:0];
        else if (v < SMP_MIN) clip_s = SMP_MIN[SMP_W-1:0];
        else                  clip_s = v[SMP_W-1:0];
    endfunction

    // keep the low sample-width bits of a wide value
    function automatic smp_t trunc_s(input acc_t v);
        trunc_s = v[SMP_W-1:0];
    endfunction

    function automatic acc_t widen(input smp_t v);
        widen = acc_t'(v);
    endfunction

endpackage

// File: rtl/fdct_row_unit.sv
// Horizontal butterfly: saturating sums/differences, gain of 8 on even
// terms, weighted and rounded odd terms with a shift of 12.
module fdct_row_unit
    import fdct_pkg::*;
(
    input  smp_t x [DIM],
    output smp_t y [DIM]
);

    smp_t sum_o, sum_i, dif_i, dif_o;
    acc_t even_p, even_m, odd_1, odd_3;

    always_comb begin
        // R2: clamped butterfly
        sum_o = clip_s(widen(x[0]) + widen(x[3]));
        sum_i = clip_s(widen(x[1]) + widen(x[2]));
        dif_i = clip_s(widen(x[1]) - widen(x[2]));
        dif_o = clip_s(widen(x[0]) - widen(x[3]));

        // R3: even terms
        even_p = (widen(sum_o) + widen(sum_i)) <<< H_GAIN_SH;
        even_m = (widen(sum_o) - widen(sum_i)) <<< H_GAIN_SH;

        // R4: odd terms
        odd_1 = (widen(dif_i) * W_SMALL + widen(dif_o) * W_LARGE + H_RND_ODD1) >>> H_ODD_SH;
        odd_3 = (widen(dif_o) * W_SMALL - widen(dif_i) * W_LARGE + H_RND_ODD3) >>> H_ODD_SH;

        y[0] = trunc_s(even_p);
        y[1] = trunc_s(odd_1);
        y[2] = trunc_s(even_m);
        y[3] = trunc_s(odd_3);
    end

endmodule

// File: rtl/fdct_col_unit.sv
// Vertical butterfly: unclamped sums/differences, +7 >>> 4 on even terms,
// >>> 16 on odd terms with a +1 on output 1 for a nonzero difference.
module fdct_col_unit
    import fdct_pkg::*;
(
    input  smp_t r [DIM],
    output smp_t y [DIM]
);

    acc_t sum_o, sum_i, dif_i, dif_o;
    acc_t even_p, even_m, odd_1, odd_3;
    logic nz_dif;

    always_comb begin
        sum_o = widen(r[0]) + widen(r[3]);
        sum_i = widen(r[1]) + widen(r[2]);
        dif_i = widen(r[1]) - widen(r[2]);
        dif_o = widen(r[0]) - widen(r[3]);

        // R5: even terms
        even_p = (sum_o + sum_i + V_RND_EVEN) >>> V_EVEN_SH;
        even_m = (sum_o - sum_i + V_RND_EVEN) >>> V_EVEN_SH;

        // R6: data-dependent correction
        nz_dif = (dif_o != '0);
        odd_1  = ((dif_i * W_SMALL + dif_o * W_LARGE + V_RND_ODD1) >>> V_ODD_SH)
               + (nz_dif ? acc_t'(1) : acc_t'(0));

        // R7: second odd term
        odd_3 = (dif_o * W_SMALL - dif_i * W_LARGE + V_RND_ODD3) >>> V_ODD_SH;

        y[0] = trunc_s(even_p);
        y[1] = trunc_s(odd_1);
        y[2] = trunc_s(even_m);
        y[3] = trunc_s(odd_3);
    end

endmodule

// File: rtl/fdct_seq.sv
// Phase sequencer: accept, four row steps, four column steps, result pulse.
module fdct_seq
    import fdct_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             load_en,
    output logic             row_en,
    output logic             col_en,
    output logic [SEL_W-1:0] sel,
    output logic             busy,
    output logic             done
);

    localparam logic [SEL_W-1:0] LAST = SEL_W'(DIM - 1);

    phase_e           state, state_nx;
    logic [SEL_W-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin          // ACCEPT
                    state_nx = ST_ROW;
                    cnt_nx   = '0;
                end
            end
            ST_ROW: begin
                if (cnt == LAST) begin    // ROWS_DONE
                    state_nx = ST_COL;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_COL: begin
                if (cnt == LAST) begin    // COLS_DONE
                    state_nx = ST_FIN;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_FIN: begin                 // RELEASE
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_en = 1'b0;
        row_en  = 1'b0;
        col_en  = 1'b0;
        done    = 1'b0;
        busy    = 1'b1;
        sel     = cnt;
        unique case (state)
            ST_IDLE: begin
                busy    = 1'b0;
                load_en = start;
            end
            ST_ROW:  row_en = 1'b1;
            ST_COL:  col_en = 1'b1;
            ST_FIN:  done   = 1'b1;
            default: busy   = 1'b0;
        endcase
    end

    // R9
    step_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_en, row_en, col_en, done}));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_last_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(col_en) && $past(sel) == LAST));

    // R10
    no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: rtl/fdct4x4_core.sv
module fdct4x4_core
    import fdct_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NUM*SMP_W-1:0] blk_in,
    output logic               busy,
    output logic               done,
    output logic [NUM*SMP_W-1:0] coef_out
);

    logic             load_en, row_en, col_en;
    logic [SEL_W-1:0] sel;

    smp_t mat    [NUM];
    smp_t in_smp [NUM];
    smp_t row_x  [DIM];
    smp_t row_y  [DIM];
    smp_t col_x  [DIM];
    smp_t col_y  [DIM];

    fdct_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load_en (load_en),
        .row_en  (row_en),
        .col_en  (col_en),
        .sel     (sel),
        .busy    (busy),
        .done    (done)
    );

    fdct_row_unit u_row (
        .x (row_x),
        .y (row_y)
    );

    fdct_col_unit u_col (
        .r (col_x),
        .y (col_y)
    );

    // R8: raster packing of inputs and outputs
    for (genvar g = 0; g < NUM; g++) begin : g_pack
        assign in_smp[g]                   = blk_in[g*SMP_W +: SMP_W];
        assign coef_out[g*SMP_W +: SMP_W]  = mat[g];
    end

    // operand selection: row sel or column sel of the working matrix
    always_comb begin
        for (int k = 0; k < DIM; k++) begin
            row_x[k] = mat[int'(sel) * DIM + k];
            col_x[k] = mat[k * DIM + int'(sel)];
        end
    end

    // in-place working matrix
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) mat[i] <= '0;
        end else if (load_en) begin
            for (int i = 0; i < NUM; i++) mat[i] <= in_smp[i];
        end else if (row_en) begin
            for (int k = 0; k < DIM; k++) mat[int'(sel) * DIM + k] <= row_y[k];
        end else if (col_en) begin
            for (int k = 0; k < DIM; k++) mat[k * DIM + int'(sel)] <= col_y[k];
        end
    end

    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(coef_out));

    // R9
    busy_begins_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

// File: tb/fdct4x4_core_test.sv
module fdct4x4_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] blk_in = '0;
    logic         busy, done;
    logic [255:0] coef_out;

    int checks = 0;
    int failures = 0;
    int unsigned lcg = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdct4x4_core uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .blk_in   (blk_in),
        .busy     (busy),
        .done     (done),
        .coef_out (coef_out)
    );

    // ---------------- reference model (from requirements) ----------------
    function automatic int t16(input int v);
        logic signed [15:0] t;
        t = v[15:0];
        return int'(t);
    endfunction

    function automatic int sat16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int smp(input logic [255:0] v, input int idx);
        logic signed [15:0] t;
        t = v[16*idx +: 16];
        return int'(t);
    endfunction

    function automatic logic [255:0] ref_dct(input logic [255:0] blk);
        int h[16];
        int a, b, c, d, x0, x1, x2, x3, o1;
        logic [255:0] res;
        res = '0;
        for (int i = 0; i < 4; i++) begin
            x0 = smp(blk, 4*i); x1 = smp(blk, 4*i+1);
            x2 = smp(blk, 4*i+2); x3 = smp(blk, 4*i+3);
            a = sat16(x0 + x3); b = sat16(x1 + x2);
            c = sat16(x1 - x2); d = sat16(x0 - x3);
            h[4*i+0] = t16((a + b) * 8);
            h[4*i+2] = t16((a - b) * 8);
            h[4*i+1] = t16((c * 2217 + d * 5352 + 14500) >>> 12);
            h[4*i+3] = t16((d * 2217 - c * 5352 + 7500) >>> 12);
        end
        for (int j = 0; j < 4; j++) begin
            a = h[j] + h[12+j]; b = h[4+j] + h[8+j];
            c = h[4+j] - h[8+j]; d = h[j] - h[12+j];
            o1 = ((c * 2217 + d * 5352 + 12000) >>> 16) + ((d != 0) ? 1 : 0);
            res[16*(0+j)  +: 16] = 16'(t16((a + b + 7) >>> 4));
            res[16*(4+j)  +: 16] = 16'(t16(o1));
            res[16*(8+j)  +: 16] = 16'(t16((a - b + 7) >>> 4));
            res[16*(12+j) +: 16] = 16'(t16((d * 2217 - c * 5352 + 51000) >>> 16));
        end
        return res;
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic string row_tag(input int k);
        case (k / 4)
            0, 2:    return "R5";
            1:       return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic cmp_all(input string scen, input logic [255:0] exp);
        for (int k = 0; k < 16; k++)
            chk({row_tag(k), " R8 ", scen}, $sformatf("coef[%0d]", k),
                smp(coef_out, k), smp(exp, k));
    endtask

    // start one tile and return the number of cycles until done
    task automatic launch_and_wait(input logic [255:0] blk, output int lat);
        @(negedge clk);
        blk_in = blk;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        lat    = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_block(input string scen, input logic [255:0] blk);
        int lat;
        launch_and_wait(blk, lat);
        chk({"R9 ", scen}, "latency", lat, LATENCY);   // R9
        chk({"R9 ", scen}, "busy with done", int'(busy), 1);
        cmp_all(scen, ref_dct(blk));
        @(negedge clk);
        chk({"R9 ", scen}, "done width", int'(done), 0);
    endtask

    function automatic logic [255:0] fill(input int v);
        logic [255:0] r;
        for (int k = 0; k < 16; k++) r[16*k +: 16] = 16'(v);
        return r;
    endfunction

    function automatic logic [15:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg[31:16];
    endfunction

    // ---------------- scenarios ----------------
    task automatic test_reset();
        // R1
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "coef_out zero", int'(coef_out == '0), 1);
    endtask

    task automatic test_zero();
        // R6: d == 0 everywhere, so no correction is added
        run_block("R6 zero", '0);
        chk("R6", "zero tile coef[4]", smp(coef_out, 4), 0);
    endtask

    task automatic test_impulse();
        logic [255:0] b;
        b = '0;
        b[15:0] = 16'sd100;
        run_block("R3 R4 impulse", b);
        b = '0;
        b[16*6 +: 16] = -16'sd250;
        run_block("R8 impulse(1,2)", b);
    endtask

    task automatic test_extremes();
        logic [255:0] b;
        // R2: sums clamp at +32767 / -32768
        run_block("R2 all max", fill(32767));
        run_block("R2 all -max", fill(-32767));
        for (int k = 0; k < 16; k++)
            b[16*k +: 16] = ((k % 2) == 0) ? 16'sh7fff : 16'sh8001;
        run_block("R2 alternating", b);
        for (int k = 0; k < 16; k++)
            b[16*k +: 16] = ((k % 4) < 2) ? 16'sh7fff : 16'sh8000;
        run_block("R2 R4 split", b);
    endtask

    task automatic test_equal_rows();
        logic [255:0] b;
        // R6: identical rows give zero column difference d
        for (int k = 0; k < 16; k++) b[16*k +: 16] = 16'((k % 4) * 37 - 60);
        run_block("R6 equal rows", b);
        // R6: rows differ so d is nonzero
        for (int k = 0; k < 16; k++) b[16*k +: 16] = 16'(k * 11 - 90);
        run_block("R6 ramp", b);
    endtask

    task automatic test_random();
        logic [255:0] b;
        for (int n = 0; n < 20; n++) begin
            for (int k = 0; k < 16; k++) b[16*k +: 16] = next_rand();
            run_block("R3 R4 R5 random", b);
        end
    endtask

    task automatic test_busy_start();
        logic [255:0] ta, tb;
        logic [255:0] ea;
        int lat;
        for (int k = 0; k < 16; k++) begin
            ta[16*k +: 16] = 16'(k * 300 - 2000);
            tb[16*k +: 16] = 16'(1500 - k * 77);
        end
        ea = ref_dct(ta);
        @(negedge clk);
        blk_in = ta;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        lat    = 0;
        repeat (3) begin @(negedge clk); lat++; end
        // R10: start mid-tile with other data
        blk_in = tb;
        start  = 1'b1;
        @(negedge clk); lat++;
        start  = 1'b0;
        while (!done && lat < 40) begin @(negedge clk); lat++; end
        chk("R10", "latency unchanged", lat, LATENCY);
        cmp_all("R10 mid-tile start", ea);
        // R10: start during the done cycle
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10", "busy after done-cycle start", int'(busy), 0);
        cmp_all("R10 done-cycle start", ea);
        repeat (10) @(negedge clk);
        chk("R10", "no second done", int'(done), 0);
        chk("R10", "still idle", int'(busy), 0);
    endtask

    task automatic test_hold();
        logic [255:0] b, e;
        for (int k = 0; k < 16; k++) b[16*k +: 16] = 16'(k * k * 13 - 700);
        e = ref_dct(b);
        run_block("R11 setup", b);
        // R11: input changes without start leave the result alone
        blk_in = fill(1234);
        repeat (6) @(negedge clk);
        chk("R11", "result held", int'(coef_out == e), 1);
    endtask

    // ---------------- main ----------------
    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_zero();
        test_impulse();
        test_extremes();
        test_equal_rows();
        test_random();
        test_busy_start();
        test_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule